// File: doc/BRIEF.md
# Host Bridge I/O Window Remapper

This block sits on the CPU side of a host bridge and classifies every CPU request by the fixed window its address falls in. Requests aimed at the I/O window are translated into bus I/O port addresses. A mode input picks how the first 8 MB of that window is folded into port space. In dense mode the CPU offset is cut to 16 bits. In sparse mode the 5 low offset bits are kept, bits 12 to 22 are moved down to port bits 5 to 15, and bits 5 to 11 are dropped, so each 4 KB page of CPU space lands on 32 consecutive ports. The rest of the I/O window passes its offset through unchanged.

The decoder also recognises four other cases. The bus memory window starts at 0xC000_0000. The single interrupt-acknowledge byte sits at 0xBFFF_FFF0. The 1 MB read-only boot ROM fills the top of the address space. Any other address is a decode error. Each request gives, one cycle later, one of three results: a forwarded access with a region code, a translated address, the size and the write data; a decode error; or a dropped ROM write. The CPU-side read data is taken from the bus, and it is forced to zero in any cycle that carries no forwarded access. The mode input is sampled together with each request, so a change of mode applies from the next request on.

Top module: `hbr_io_remap`

## Requirements
- R1: In the cycle after synchronous reset is released, out_valid, err_decode and err_rom_write are all low.
- R2: Each request held on req_valid for one cycle raises exactly one of out_valid, err_decode or err_rom_write in the next cycle. A cycle with req_valid low raises none of them in the next cycle.
- R3: With req_mode low, an access in 0x8000_0000..0x807F_FFFF is forwarded with region code 1 (I/O), and out_addr is the offset from 0x8000_0000 cut to its low 16 bits.
- R4: With req_mode high, an access in that same 8 MB window is forwarded with region code 1. out_addr takes offset bits 4..0 in port bits 4..0 and offset bits 22..12 in port bits 15..5; all higher bits are zero.
- R5: An access in 0x8080_0000..0xBF7F_FFFF is forwarded with region code 1 and out_addr equal to the offset from 0x8000_0000, in either mode.
- R6: An access in 0xC000_0000..0xFEFF_FFFF is forwarded with region code 2 (bus memory) and out_addr equal to the address minus 0xC000_0000.
- R7: A 1-byte access at 0xBFFF_FFF0 is forwarded with region code 3 (interrupt acknowledge) and out_addr zero. Any other size at that address is a decode error.
- R8: A read in 0xFFF0_0000..0xFFFF_FFFF is forwarded with region code 4 (boot ROM) and out_addr equal to the offset from 0xFFF0_0000. A write there is dropped: err_rom_write is raised and out_valid stays low.
- R9: An address in no window, or size code 3, raises err_decode, and cpu_rdata is zero in that cycle.
- R10: Size codes 0, 1 and 2 (1, 2 and 4 bytes) are forwarded unchanged on out_size, even at unaligned addresses. Write data is forwarded unchanged in little-endian lane order (the lowest-addressed byte in bits 7:0). During a forwarded access cpu_rdata equals bus_rdata.
- R11: The mode is taken from req_mode in the cycle of each request, so back-to-back requests to the same address with different modes are translated differently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A CPU request is present this cycle |
| req_addr | input | 32 | CPU byte address |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=illegal |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DATA_W | Write data, little-endian lanes |
| req_mode | input | 1 | I/O fold mode: 0 dense, 1 sparse |
| bus_rdata | input | DATA_W | Read data returned by the bus side |
| out_valid | output | 1 | Forwarded access present |
| out_region | output | 3 | 0 none, 1 I/O, 2 bus memory, 3 interrupt acknowledge, 4 boot ROM |
| out_addr | output | 32 | Translated address or offset |
| out_size | output | 2 | Forwarded size code |
| out_write | output | 1 | Forwarded direction |
| out_wdata | output | DATA_W | Forwarded write data |
| err_decode | output | 1 | Request matched no window or had an illegal size |
| err_rom_write | output | 1 | Write to the boot ROM was dropped |
| cpu_rdata | output | DATA_W | Read data to the CPU, zero unless out_valid |

## Verification
The bench walks each window edge: the last byte of the 8 MB folded window, the first byte past it, the last I/O byte and the first byte past it, both ends of bus memory, the gap below the ROM and the very top address. A design with an off-by-one span would put the byte past an edge in the wrong region or raise a false decode error. The sparse fold is checked with offsets whose dropped bits 5..11 are nonzero and at the all-ones corner, where a wrong shift or mask gives a different port. Back-to-back requests that flip the mode catch a decoder that latches the mode late. A 2-byte access to the acknowledge byte, a ROM write and size code 3 check that rejected requests never reach out_valid and that the CPU read data stays zero.

// File: rtl/hbr_pkg.sv
`timescale 1ns/1ps
package hbr_pkg;

    localparam int ADDR_W = 32;

    // Region codes seen at out_region
    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_IO   = 3'd1,
        RGN_MEM  = 3'd2,
        RGN_IACK = 3'd3,
        RGN_ROM  = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        SZ_1   = 2'd0,
        SZ_2   = 2'd1,
        SZ_4   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    // Sparse fold geometry: low bits kept, upper slice moved down
    localparam int SPARSE_LOW_W    = 5;
    localparam int SPARSE_HIGH_LSB = 12;
    localparam int SPARSE_HIGH_W   = 11;
    localparam int SPARSE_TOP_BIT  = SPARSE_HIGH_LSB + SPARSE_HIGH_W;
    localparam logic [ADDR_W-1:0] SPARSE_SPAN = ADDR_W'(1) << SPARSE_TOP_BIT;

    // Fixed CPU windows
    localparam logic [ADDR_W-1:0] IO_BASE   = 32'h8000_0000;
    localparam logic [ADDR_W-1:0] IO_SPAN   = 32'h3F80_0000;
    localparam logic [ADDR_W-1:0] IACK_BASE = 32'hBFFF_FFF0;
    localparam logic [ADDR_W-1:0] IACK_SPAN = 32'h0000_0001;
    localparam logic [ADDR_W-1:0] MEM_BASE  = 32'hC000_0000;
    localparam logic [ADDR_W-1:0] MEM_SPAN  = 32'h3F00_0000;
    localparam logic [ADDR_W-1:0] ROM_BASE  = 32'hFFF0_0000;
    localparam logic [ADDR_W-1:0] ROM_SPAN  = 32'h0010_0000;

    localparam int NUM_WIN  = 4;
    localparam int WIN_IO   = 0;
    localparam int WIN_IACK = 1;
    localparam int WIN_MEM  = 2;
    localparam int WIN_ROM  = 3;

    typedef struct packed {
        region_e           region;
        logic              in_fold;   // inside the first 8 MB of I/O
        logic              rom_wr;    // write aimed at the ROM
        logic [ADDR_W-1:0] offset;    // offset from the window base
    } decode_t;

    function automatic logic [ADDR_W-1:0] win_base(input int idx);
        case (idx)
            WIN_IO:   return IO_BASE;
            WIN_IACK: return IACK_BASE;
            WIN_MEM:  return MEM_BASE;
            default:  return ROM_BASE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] win_span(input int idx);
        case (idx)
            WIN_IO:   return IO_SPAN;
            WIN_IACK: return IACK_SPAN;
            WIN_MEM:  return MEM_SPAN;
            default:  return ROM_SPAN;
        endcase
    endfunction

endpackage

// File: rtl/hbr_window_decode.sv
`timescale 1ns/1ps
module hbr_window_decode
    import hbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    output decode_t           dec
);

    logic [NUM_WIN-1:0] hit;
    logic [ADDR_W-1:0]  rel [NUM_WIN];

    // One wrap-around subtract and compare per window
    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            assign rel[w] = addr - win_base(w);
            assign hit[w] = rel[w] < win_span(w);
        end
    endgenerate

    always_comb begin
        dec        = '0;
        dec.region = RGN_NONE;
        if (size_e'(size) == SZ_BAD) begin
            dec.region = RGN_NONE;
        end else if (hit[WIN_IO]) begin
            dec.region  = RGN_IO;
            dec.offset  = rel[WIN_IO];
            dec.in_fold = rel[WIN_IO] < SPARSE_SPAN;
        end else if (hit[WIN_IACK]) begin
            if (size_e'(size) == SZ_1) begin
                dec.region = RGN_IACK;
                dec.offset = rel[WIN_IACK];
            end
        end else if (hit[WIN_MEM]) begin
            dec.region = RGN_MEM;
            dec.offset = rel[WIN_MEM];
        end else if (hit[WIN_ROM]) begin
            dec.region = RGN_ROM;
            dec.offset = rel[WIN_ROM];
            dec.rom_wr = write;
        end
    end

endmodule

// File: rtl/hbr_io_xlate.sv
`timescale 1ns/1ps
module hbr_io_xlate
    import hbr_pkg::*;
#(
    parameter int PORT_W    = 16,
    parameter bit SPARSE_EN = 1'b1
) (
    input  region_e           region,
    input  logic              in_fold,
    input  logic [ADDR_W-1:0] offset,
    input  logic              mode,
    output logic [ADDR_W-1:0] xaddr
);

    localparam int PAD_W = ADDR_W - PORT_W;

    logic [ADDR_W-1:0] dense_port;
    logic [ADDR_W-1:0] sparse_port;

    assign dense_port = {{PAD_W{1'b0}}, offset[PORT_W-1:0]};

    generate
        if (SPARSE_EN) begin : g_sparse
            assign sparse_port = {{PAD_W{1'b0}},
                                  offset[SPARSE_TOP_BIT-1:SPARSE_HIGH_LSB],
                                  offset[SPARSE_LOW_W-1:0]};
        end else begin : g_dense_only
            assign sparse_port = dense_port;
        end
    endgenerate

    always_comb begin
        if (region == RGN_IO && in_fold) begin
            xaddr = mode ? sparse_port : dense_port;
        end else begin
            xaddr = offset;
        end
    end

endmodule

// File: rtl/hbr_req_stage.sv
`timescale 1ns/1ps
module hbr_req_stage
    import hbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  region_e           in_region,
    input  logic              in_rom_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_size,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              q_valid,
    output region_e           q_region,
    output logic [ADDR_W-1:0] q_addr,
    output logic [1:0]        q_size,
    output logic              q_write,
    output logic [DATA_W-1:0] q_wdata,
    output logic              q_err_decode,
    output logic              q_err_rom
);

    logic fwd;
    logic bad;

    assign bad = in_region == RGN_NONE;
    assign fwd = in_valid && !bad && !in_rom_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid      <= 1'b0;
            q_region     <= RGN_NONE;
            q_err_decode <= 1'b0;
            q_err_rom    <= 1'b0;
        end else begin
            q_valid      <= fwd;
            q_region     <= fwd ? in_region : RGN_NONE;
            q_err_decode <= in_valid && bad;
            q_err_rom    <= in_valid && !bad && in_rom_wr;
        end
    end

    // Payload needs no reset; it is qualified by q_valid
    always_ff @(posedge clk) begin
        if (fwd) begin
            q_addr  <= in_addr;
            q_size  <= in_size;
            q_write <= in_write;
            q_wdata <= in_wdata;
        end
    end

endmodule

// File: rtl/hbr_io_remap.sv
`timescale 1ns/1ps
module hbr_io_remap
    import hbr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PORT_W    = 16,
    parameter bit SPARSE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_mode,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              out_valid,
    output logic [2:0]        out_region,
    output logic [31:0]       out_addr,
    output logic [1:0]        out_size,
    output logic              out_write,
    output logic [DATA_W-1:0] out_wdata,
    output logic              err_decode,
    output logic              err_rom_write,
    output logic [DATA_W-1:0] cpu_rdata
);

    decode_t           dec;
    logic [ADDR_W-1:0] xaddr;
    region_e           region_q;

    hbr_window_decode u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .write (req_write),
        .dec   (dec)
    );

    hbr_io_xlate #(
        .PORT_W    (PORT_W),
        .SPARSE_EN (SPARSE_EN)
    ) u_xlate (
        .region  (dec.region),
        .in_fold (dec.in_fold),
        .offset  (dec.offset),
        .mode    (req_mode),
        .xaddr   (xaddr)
    );

    hbr_req_stage #(
        .DATA_W (DATA_W)
    ) u_stage (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (req_valid),
        .in_region    (dec.region),
        .in_rom_wr    (dec.rom_wr),
        .in_addr      (xaddr),
        .in_size      (req_size),
        .in_write     (req_write),
        .in_wdata     (req_wdata),
        .q_valid      (out_valid),
        .q_region     (region_q),
        .q_addr       (out_addr),
        .q_size       (out_size),
        .q_write      (out_write),
        .q_wdata      (out_wdata),
        .q_err_decode (err_decode),
        .q_err_rom    (err_rom_write)
    );

    assign out_region = region_q;
    assign cpu_rdata  = out_valid ? bus_rdata : '0;

endmodule

// File: rtl/hbr_io_remap_chk.sv
`timescale 1ns/1ps
module hbr_io_remap_chk
    import hbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic [1:0]        req_size,
    input logic              req_write,
    input logic              req_mode,
    input logic              out_valid,
    input logic [2:0]        out_region,
    input logic [31:0]       out_addr,
    input logic [1:0]        out_size,
    input logic              err_decode,
    input logic              err_rom_write,
    input logic [DATA_W-1:0] cpu_rdata
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !err_decode && !err_rom_write);

    a_r2_one_result: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> $countones({out_valid, err_decode, err_rom_write}) == 1);

    a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid && !err_decode && !err_rom_write);

    a_r3_dense_fold: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_region == 3'd1 && !$past(req_mode)
        && $past((req_addr - IO_BASE) < SPARSE_SPAN)
        |-> out_addr == 32'($past(req_addr[PORT_W-1:0])));

    a_r4_sparse_bounded: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_region == 3'd1 && $past(req_mode)
        && $past((req_addr - IO_BASE) < SPARSE_SPAN)
        |-> out_addr[31:PORT_W] == '0);

    a_r7_iack_byte_only: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_region == 3'd3 |-> out_size == 2'd0);

    a_r8_rom_write_dropped: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_size != 2'd3 && req_addr >= ROM_BASE
        |=> err_rom_write && !out_valid);

    a_r9_zero_read_on_error: assert property (@(posedge clk) disable iff (rst)
        err_decode |-> cpu_rdata == '0);

endmodule

bind hbr_io_remap hbr_io_remap_chk #(
    .DATA_W (DATA_W),
    .PORT_W (PORT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_write     (req_write),
    .req_mode      (req_mode),
    .out_valid     (out_valid),
    .out_region    (out_region),
    .out_addr      (out_addr),
    .out_size      (out_size),
    .err_decode    (err_decode),
    .err_rom_write (err_rom_write),
    .cpu_rdata     (cpu_rdata)
);

// File: tb/hbr_io_remap_bench.sv
`timescale 1ns/1ps
module hbr_io_remap_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        req_mode;
    logic [31:0] bus_rdata;
    logic        out_valid;
    logic [2:0]  out_region;
    logic [31:0] out_addr;
    logic [1:0]  out_size;
    logic        out_write;
    logic [31:0] out_wdata;
    logic        err_decode;
    logic        err_rom_write;
    logic [31:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_en = 1'b0;

    // kind: 0 idle, 1 forwarded, 2 decode error, 3 dropped ROM write
    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  region;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        write;
        logic [31:0] wdata;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    always #2 clk = ~clk;

    hbr_io_remap u_hbr_io_remap (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .req_mode      (req_mode),
        .bus_rdata     (bus_rdata),
        .out_valid     (out_valid),
        .out_region    (out_region),
        .out_addr      (out_addr),
        .out_size      (out_size),
        .out_write     (out_write),
        .out_wdata     (out_wdata),
        .err_decode    (err_decode),
        .err_rom_write (err_rom_write),
        .cpu_rdata     (cpu_rdata)
    );

    // Expected result written from the requirement text
    function automatic exp_t model(input logic [31:0] a, input logic [1:0] sz,
                                   input logic wr, input logic [31:0] wd,
                                   input logic md);
        exp_t        e;
        logic [31:0] off;
        e       = '0;
        e.size  = sz;
        e.write = wr;
        e.wdata = wd;
        off     = a - 32'h8000_0000;
        if (sz == 2'd3) begin
            e.kind = 2'd2;
        end else if (a >= 32'h8000_0000 && a <= 32'h807F_FFFF) begin
            e.kind   = 2'd1;
            e.region = 3'd1;
            if (md) e.addr = {16'h0, off[22:12], off[4:0]};
            else    e.addr = {16'h0, off[15:0]};
        end else if (a >= 32'h8080_0000 && a <= 32'hBF7F_FFFF) begin
            e.kind   = 2'd1;
            e.region = 3'd1;
            e.addr   = off;
        end else if (a == 32'hBFFF_FFF0) begin
            if (sz == 2'd0) begin
                e.kind   = 2'd1;
                e.region = 3'd3;
                e.addr   = 32'h0;
            end else begin
                e.kind = 2'd2;
            end
        end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
            e.kind   = 2'd1;
            e.region = 3'd2;
            e.addr   = a - 32'hC000_0000;
        end else if (a >= 32'hFFF0_0000) begin
            if (wr) begin
                e.kind = 2'd3;
            end else begin
                e.kind   = 2'd1;
                e.region = 3'd4;
                e.addr   = a - 32'hFFF0_0000;
            end
        end else begin
            e.kind = 2'd2;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(input string tag, input logic [31:0] a, input logic [1:0] sz,
                        input logic wr, input logic [31:0] wd, input logic md);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        req_wdata = wd;
        req_mode  = md;
        expq.push_back(model(a, sz, wr, wd, md));
        tagq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'h0;
        req_mode  = ~req_mode;   // toggling while idle must not matter
        e         = '0;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: one item per cycle, sampled just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && expq.size() > 0) begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                case (e.kind)
                    2'd0: check(!out_valid && !err_decode && !err_rom_write, t,
                                "idle result flags",
                                {29'h0, out_valid, err_decode, err_rom_write}, 32'h0);
                    2'd1: begin
                        check(out_valid && !err_decode && !err_rom_write, t,
                              "forward flags",
                              {29'h0, out_valid, err_decode, err_rom_write}, 32'h4);
                        check(out_region == e.region, t, "region",
                              {29'h0, out_region}, {29'h0, e.region});
                        check(out_addr == e.addr, t, "addr", out_addr, e.addr);
                        check(out_size == e.size && out_write == e.write, t,
                              "size/write", {29'h0, out_write, out_size},
                              {29'h0, e.write, e.size});
                        check(out_wdata == e.wdata, t, "wdata", out_wdata, e.wdata);
                        check(cpu_rdata == bus_rdata, t, "rdata pass R10",
                              cpu_rdata, bus_rdata);
                    end
                    2'd2: begin
                        check(err_decode && !out_valid && !err_rom_write, t,
                              "decode error flags",
                              {29'h0, out_valid, err_decode, err_rom_write}, 32'h2);
                        check(cpu_rdata == 32'h0, t, "zero read R9",
                              cpu_rdata, 32'h0);
                    end
                    default: check(err_rom_write && !out_valid && !err_decode, t,
                                   "rom write drop flags",
                                   {29'h0, out_valid, err_decode, err_rom_write},
                                   32'h1);
                endcase
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = 32'h0;
        req_size  = 2'd0;
        req_write = 1'b0;
        req_wdata = 32'h0;
        req_mode  = 1'b0;
        bus_rdata = 32'hA5C3_1E7B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state
        check(!out_valid && !err_decode && !err_rom_write, "R1", "reset flags",
              {29'h0, out_valid, err_decode, err_rom_write}, 32'h0);
        check(cpu_rdata == 32'h0, "R1", "reset rdata", cpu_rdata, 32'h0);
        mon_en = 1'b1;

        // R3: dense fold of the first 8 MB
        send("R3", 32'h8000_03F8, 2'd0, 1'b1, 32'h0000_005A, 1'b0);
        send("R3", 32'h8012_3456, 2'd1, 1'b0, 32'h0, 1'b0);
        send("R3", 32'h807F_FFFF, 2'd0, 1'b0, 32'h0, 1'b0);
        // R4: sparse fold, dropped bits 5..11 set
        send("R4", 32'h8000_0CF8, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b1);
        send("R4", 32'h8012_3456, 2'd0, 1'b0, 32'h0, 1'b1);
        send("R4", 32'h807F_FFFF, 2'd0, 1'b0, 32'h0, 1'b1);
        send("R4", 32'h8000_0FE0, 2'd0, 1'b0, 32'h0, 1'b1);
        // R5: rest of I/O window in both modes, and edges
        send("R5", 32'h8080_0000, 2'd0, 1'b0, 32'h0, 1'b1);
        send("R5", 32'h8080_0000, 2'd0, 1'b0, 32'h0, 1'b0);
        send("R5", 32'hBF7F_FFFF, 2'd0, 1'b1, 32'h11, 1'b0);
        send("R9", 32'hBF80_0000, 2'd0, 1'b0, 32'h0, 1'b0);
        // R2: idle gaps
        idle("R2");
        idle("R2");
        // R6: bus memory and its edges
        send("R6", 32'hC000_0000, 2'd2, 1'b0, 32'h0, 1'b0);
        send("R6", 32'hFEFF_FFFC, 2'd2, 1'b1, 32'h0BAD_F00D, 1'b1);
        send("R9", 32'hFF00_0000, 2'd0, 1'b0, 32'h0, 1'b0);
        send("R9", 32'hBFFF_FFEF, 2'd0, 1'b0, 32'h0, 1'b0);
        // R7: interrupt acknowledge
        send("R7", 32'hBFFF_FFF0, 2'd0, 1'b0, 32'h0, 1'b0);
        send("R7", 32'hBFFF_FFF0, 2'd1, 1'b0, 32'h0, 1'b0);
        send("R7", 32'hBFFF_FFF1, 2'd0, 1'b0, 32'h0, 1'b0);
        // R8: boot ROM reads and dropped write
        send("R8", 32'hFFF0_0000, 2'd2, 1'b0, 32'h0, 1'b0);
        send("R8", 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0, 1'b1);
        send("R8", 32'hFFF8_0000, 2'd2, 1'b1, 32'h1234_5678, 1'b0);
        send("R8", 32'hFFEF_FFFF, 2'd0, 1'b0, 32'h0, 1'b0);
        // R9: low memory and illegal size
        send("R9", 32'h1000_0000, 2'd2, 1'b0, 32'h0, 1'b0);
        send("R9", 32'hC000_0000, 2'd3, 1'b0, 32'h0, 1'b0);
        // R10: unaligned sizes, little-endian data forwarded as is
        send("R10", 32'h8000_0001, 2'd2, 1'b1, 32'h4433_2211, 1'b0);
        send("R10", 32'hC000_0003, 2'd1, 1'b1, 32'h0000_BEAD, 1'b0);
        // R11: mode flips between back-to-back requests
        send("R11", 32'h8012_3456, 2'd0, 1'b0, 32'h0, 1'b1);
        send("R11", 32'h8012_3456, 2'd0, 1'b0, 32'h0, 1'b0);
        send("R11", 32'h8012_3456, 2'd0, 1'b0, 32'h0, 1'b1);
        idle("R2");
        idle("R2");

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R2", "scoreboard drained",
              32'(expq.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule